// File: doc/BRIEF.md
# Command-Locked Control Register File

This block is the host-facing control and status register file of a card-host controller. The host reads and writes it through a simple synchronous word port. Nine configuration registers are presented continuously to the card-side logic: command, argument, byte count, block size, clock divider, clock enable, clock source, timeout and card width. Writing the command register with its start bit set hands that set to the card side and locks it.

While the lock is held, host writes to any of the nine registers are dropped. Each dropped write sets a lock-error bit in a raw interrupt status register. The card side ends the lock with a one-cycle accept pulse, which also clears the start bit that the host reads back. The global control, interrupt mask and raw status registers stay writable at all times. An interrupt line is driven from the raw status, the mask and a global enable.

The lock is a two-state machine. In state LK_OPEN the configuration registers are writable. Transition START (a command write with bit 31 set, taken in LK_OPEN) moves it to LK_HELD. In LK_HELD all configuration writes are dropped. Transition ACCEPT (an accept pulse, taken in LK_HELD) returns it to LK_OPEN. In every other case each state holds. All state sits in the host clock domain.

Top module: `cmd_lock_regfile`

Word address map: 0 global control (bit 0 is the interrupt enable), 1 interrupt mask, 2 raw interrupt status, 4 clock divider, 5 clock source, 6 clock enable, 7 timeout, 8 card width, 9 block size, 10 byte count, 11 argument, 12 command. Addresses 3 and 13 to 31 are unmapped.

## Requirements
- R1: After reset, every register reads 0 except timeout (all ones), block size (0x200) and byte count (0x200). cmd_pending_o and irq_o are 0.
- R2: A write to address 12 with bit 31 = 1 while unlocked stores bits 30:0 and takes the lock. From the next cycle, cmd_pending_o = 1 and address 12 reads back with bit 31 = 1. A write with bit 31 = 0 stores the bits and does not lock.
- R3: While locked, a write to any address from 4 to 12 is dropped, and the register keeps its value.
- R4: Each dropped locked write sets raw status bit 12 (the lock-error bit).
- R5: An accept pulse while locked clears the lock on the next edge. Address 12 then reads bit 31 = 0, and later configuration writes take effect.
- R6: A configuration write in the same cycle as the accept pulse is still treated as locked. It is dropped and sets bit 12.
- R7: Writes to addresses 0, 1 and 2 take effect during the lock and never set the lock-error bit.
- R8: Writing 1 to a raw status bit at address 2 clears it. Bits written 0 are unchanged.
- R9: irq_o equals the OR over all bits of (raw status AND mask), gated by global control bit 0.
- R10: Read data appears on host_rdata_o one cycle after host_rd_i. Unmapped addresses read 0, and writes to them change nothing and set no error.
- R11: An accept pulse while unlocked has no effect.
- R12: The cfg_* outputs always show the stored register values. cfg_cmd_o bit 31 shows the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Write strobe |
| host_rd_i | input | 1 | Read strobe |
| host_addr_i | input | ADDR_W | Word address |
| host_wdata_i | input | DATA_W | Write data |
| host_rdata_o | output | DATA_W | Read data, registered |
| card_accept_i | input | 1 | One-cycle command accept pulse from card side |
| cmd_pending_o | output | 1 | Lock held (start bit) |
| cfg_clkdiv_o | output | DATA_W | Clock divider |
| cfg_clksrc_o | output | DATA_W | Clock source |
| cfg_clken_o | output | DATA_W | Clock enable |
| cfg_timeout_o | output | DATA_W | Timeout |
| cfg_cwidth_o | output | DATA_W | Card width |
| cfg_blksize_o | output | DATA_W | Block size |
| cfg_bytecnt_o | output | DATA_W | Byte count |
| cfg_arg_o | output | DATA_W | Command argument |
| cfg_cmd_o | output | DATA_W | Command word, bit 31 = start |
| irq_o | output | 1 | Interrupt line |

## Verification
The lock is tried with several write patterns. A command write without the start bit shows that storing and locking are separate. Writes to argument, block size and command during the lock show that the data is dropped and the error is flagged. Mask, raw-status and enable writes during the lock show that the unlocked registers stay live. A write in the accept cycle separates "accept wins" from "lock wins". An accept pulse while unlocked shows that the start transition is not mis-triggered, and unmapped writes show that address decoding does not leak into the lock-error logic.

// File: rtl/cmdlk_pkg.sv
package cmdlk_pkg;

    typedef enum logic [0:0] {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    localparam int A_GCTRL    = 0;
    localparam int A_IMASK    = 1;
    localparam int A_RAW      = 2;
    localparam int A_CFG_BASE = 4;
    localparam int NUM_CFG    = 9;

    // index within the configuration bank
    localparam int CFG_CLKDIV = 0;
    localparam int CFG_CLKSRC = 1;
    localparam int CFG_CLKEN  = 2;
    localparam int CFG_TMOUT  = 3;
    localparam int CFG_CWIDTH = 4;
    localparam int CFG_BLKSZ  = 5;
    localparam int CFG_BYTCNT = 6;
    localparam int CFG_ARG    = 7;
    localparam int CFG_CMD    = 8;

endpackage

// File: rtl/cmdlk_lock_fsm.sv
module cmdlk_lock_fsm
    import cmdlk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req_i,
    input  logic accept_i,
    output logic held_o
);

    lock_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (start_req_i) state_d = LK_HELD;  // START
            LK_HELD: if (accept_i)    state_d = LK_OPEN;  // ACCEPT
            default: state_d = LK_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        held_o = (state_q == LK_HELD);
    end

endmodule

// File: rtl/cmdlk_cfg_bank.sv
module cmdlk_cfg_bank
    import cmdlk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              held_i,
    output logic [DATA_W-1:0] cfg_o [NUM_CFG],
    output logic [DATA_W-1:0] rdata_o,
    output logic              hit_o,
    output logic              start_req_o,
    output logic              lock_err_o
);

    localparam logic [ADDR_W-1:0] BASE  = ADDR_W'(A_CFG_BASE);
    localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(A_CFG_BASE + NUM_CFG - 1);
    localparam int                START = DATA_W - 1;

    logic [ADDR_W-1:0] idx;
    logic              wr_ok;

    function automatic logic [DATA_W-1:0] rst_val(input int k);
        unique case (k)
            CFG_TMOUT:             return '1;
            CFG_BLKSZ, CFG_BYTCNT: return DATA_W'(512);
            default:               return '0;
        endcase
    endfunction

    always_comb begin
        hit_o       = (addr_i >= BASE) && (addr_i <= LAST);
        idx         = addr_i - BASE;
        wr_ok       = wr_i && hit_o && !held_i;
        lock_err_o  = wr_i && hit_o && held_i;
        start_req_o = wr_ok && (idx == ADDR_W'(CFG_CMD)) && wdata_i[START];
    end

    for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
        localparam logic [DATA_W-1:0] KEEP =
            (k == CFG_CMD) ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= rst_val(k);
            else if (wr_ok && (idx == ADDR_W'(k)))
                q <= wdata_i & KEEP;
        end
        assign cfg_o[k] = q;
    end

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NUM_CFG; k++) begin
            if (hit_o && (idx == ADDR_W'(k))) rdata_o = cfg_o[k];
        end
        if (hit_o && (idx == ADDR_W'(CFG_CMD))) rdata_o[START] = held_i;
    end

endmodule

// File: rtl/cmdlk_irq_unit.sv
module cmdlk_irq_unit
    import cmdlk_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 5,
    parameter int INT_W        = 16,
    parameter int LOCK_ERR_BIT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              lock_err_i,
    output logic [INT_W-1:0]  raw_o,
    output logic [INT_W-1:0]  mask_o,
    output logic              gen_o,
    output logic              irq_o
);

    logic [INT_W-1:0] raw_q, raw_d, mask_q, clr, set;
    logic             gen_q;

    always_comb begin
        clr   = (wr_i && addr_i == ADDR_W'(A_RAW)) ? wdata_i[INT_W-1:0] : '0;
        set   = lock_err_i ? (INT_W'(1) << LOCK_ERR_BIT) : '0;
        raw_d = (raw_q & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
            gen_q  <= 1'b0;
        end else begin
            raw_q <= raw_d;
            if (wr_i && addr_i == ADDR_W'(A_IMASK)) mask_q <= wdata_i[INT_W-1:0];
            if (wr_i && addr_i == ADDR_W'(A_GCTRL)) gen_q  <= wdata_i[0];
        end
    end

    always_comb begin
        raw_o  = raw_q;
        mask_o = mask_q;
        gen_o  = gen_q;
        irq_o  = gen_q && (|(raw_q & mask_q));
    end

endmodule

// File: rtl/cmd_lock_regfile.sv
module cmd_lock_regfile
    import cmdlk_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 5,
    parameter int INT_W        = 16,
    parameter int LOCK_ERR_BIT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_i,
    input  logic              host_rd_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic [DATA_W-1:0] host_rdata_o,
    input  logic              card_accept_i,
    output logic              cmd_pending_o,
    output logic [DATA_W-1:0] cfg_clkdiv_o,
    output logic [DATA_W-1:0] cfg_clksrc_o,
    output logic [DATA_W-1:0] cfg_clken_o,
    output logic [DATA_W-1:0] cfg_timeout_o,
    output logic [DATA_W-1:0] cfg_cwidth_o,
    output logic [DATA_W-1:0] cfg_blksize_o,
    output logic [DATA_W-1:0] cfg_bytecnt_o,
    output logic [DATA_W-1:0] cfg_arg_o,
    output logic [DATA_W-1:0] cfg_cmd_o,
    output logic              irq_o
);

    logic              held, start_req, lock_err, cfg_hit;
    logic [DATA_W-1:0] cfg [NUM_CFG];
    logic [DATA_W-1:0] cfg_rdata, rd_word, rdata_q;
    logic [INT_W-1:0]  irq_raw, irq_mask;
    logic              irq_gen;

    cmdlk_lock_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req_i (start_req),
        .accept_i    (card_accept_i),
        .held_o      (held)
    );

    cmdlk_cfg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (host_wr_i),
        .addr_i      (host_addr_i),
        .wdata_i     (host_wdata_i),
        .held_i      (held),
        .cfg_o       (cfg),
        .rdata_o     (cfg_rdata),
        .hit_o       (cfg_hit),
        .start_req_o (start_req),
        .lock_err_o  (lock_err)
    );

    cmdlk_irq_unit #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .INT_W(INT_W), .LOCK_ERR_BIT(LOCK_ERR_BIT)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (host_wr_i),
        .addr_i     (host_addr_i),
        .wdata_i    (host_wdata_i),
        .lock_err_i (lock_err),
        .raw_o      (irq_raw),
        .mask_o     (irq_mask),
        .gen_o      (irq_gen),
        .irq_o      (irq_o)
    );

    always_comb begin
        rd_word = '0;
        if (cfg_hit)                                 rd_word = cfg_rdata;
        else if (host_addr_i == ADDR_W'(A_GCTRL))    rd_word = DATA_W'(irq_gen);
        else if (host_addr_i == ADDR_W'(A_IMASK))    rd_word = DATA_W'(irq_mask);
        else if (host_addr_i == ADDR_W'(A_RAW))      rd_word = DATA_W'(irq_raw);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rdata_q <= '0;
        else if (host_rd_i) rdata_q <= rd_word;
    end

    always_comb begin
        host_rdata_o  = rdata_q;
        cmd_pending_o = held;
        cfg_clkdiv_o  = cfg[CFG_CLKDIV];
        cfg_clksrc_o  = cfg[CFG_CLKSRC];
        cfg_clken_o   = cfg[CFG_CLKEN];
        cfg_timeout_o = cfg[CFG_TMOUT];
        cfg_cwidth_o  = cfg[CFG_CWIDTH];
        cfg_blksize_o = cfg[CFG_BLKSZ];
        cfg_bytecnt_o = cfg[CFG_BYTCNT];
        cfg_arg_o     = cfg[CFG_ARG];
        cfg_cmd_o     = {held, cfg[CFG_CMD][DATA_W-2:0]};
    end

endmodule

// File: rtl/cmdlk_checker.sv
module cmdlk_checker
    import cmdlk_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 5,
    parameter int INT_W        = 16,
    parameter int LOCK_ERR_BIT = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr_i,
    input logic [ADDR_W-1:0] host_addr_i,
    input logic [DATA_W-1:0] host_wdata_i,
    input logic              card_accept_i,
    input logic              cmd_pending_o,
    input logic [DATA_W-1:0] cfg_arg_o,
    input logic [DATA_W-1:0] cfg_blksize_o,
    input logic [DATA_W-1:0] cfg_cmd_o,
    input logic [INT_W-1:0]  irq_raw,
    input logic              irq_o
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(A_CFG_BASE);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(A_CFG_BASE + NUM_CFG - 1);
    localparam logic [ADDR_W-1:0] CMDA = ADDR_W'(A_CFG_BASE + CFG_CMD);

    logic cfg_wr;
    assign cfg_wr = host_wr_i && (host_addr_i >= BASE) && (host_addr_i <= LAST);

    AST_START_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && host_addr_i == CMDA && host_wdata_i[DATA_W-1] && !cmd_pending_o)
        |=> cmd_pending_o); // R2

    AST_LOCK_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pending_o && !card_accept_i) |=> cmd_pending_o); // R5

    AST_ACCEPT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pending_o && card_accept_i) |=> !cmd_pending_o); // R5

    AST_LOCKED_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pending_o |=> ($stable(cfg_arg_o) && $stable(cfg_blksize_o)
                           && $stable(cfg_cmd_o[DATA_W-2:0]))); // R3

    AST_LOCKED_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pending_o && cfg_wr) |=> irq_raw[LOCK_ERR_BIT]); // R4

    AST_IDLE_ACCEPT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_pending_o && !host_wr_i) |=> !cmd_pending_o); // R11

    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_raw != '0)); // R9

endmodule

bind cmd_lock_regfile cmdlk_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .INT_W(INT_W), .LOCK_ERR_BIT(LOCK_ERR_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr_i     (host_wr_i),
    .host_addr_i   (host_addr_i),
    .host_wdata_i  (host_wdata_i),
    .card_accept_i (card_accept_i),
    .cmd_pending_o (cmd_pending_o),
    .cfg_arg_o     (cfg_arg_o),
    .cfg_blksize_o (cfg_blksize_o),
    .cfg_cmd_o     (cfg_cmd_o),
    .irq_raw       (irq_raw),
    .irq_o         (irq_o)
);

// File: tb/sim_cmd_lock_regfile.sv
`timescale 1ns/1ps
module sim_cmd_lock_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_i = 1'b0, host_rd_i = 1'b0, card_accept_i = 1'b0;
    logic [4:0]  host_addr_i = '0;
    logic [31:0] host_wdata_i = '0;
    logic [31:0] host_rdata_o;
    logic        cmd_pending_o, irq_o;
    logic [31:0] cfg_clkdiv_o, cfg_clksrc_o, cfg_clken_o, cfg_timeout_o, cfg_cwidth_o;
    logic [31:0] cfg_blksize_o, cfg_bytecnt_o, cfg_arg_o, cfg_cmd_o;

    always #2 clk = ~clk;  // 250 MHz

    cmd_lock_regfile u0 (.*);

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // requirement-level model
    logic [31:0] m_reg [0:31];
    bit          m_locked = 1'b0, m_gen = 1'b0;
    logic [15:0] m_mask = '0, m_raw = '0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_d = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int a);
        if (a == 0)              return {31'b0, m_gen};
        if (a == 1)              return {16'b0, m_mask};
        if (a == 2)              return {16'b0, m_raw};
        if (a == 12)             return {m_locked, m_reg[12][30:0]};
        if (a >= 4 && a <= 11)   return m_reg[a];
        return 32'h0;
    endfunction

    function automatic bit m_irq();
        return m_gen && (|(m_raw & m_mask));
    endfunction

    task automatic chk_outs(input string tag);
        chk({tag, " clkdiv"},  cfg_clkdiv_o,  m_reg[4]);
        chk({tag, " clksrc"},  cfg_clksrc_o,  m_reg[5]);
        chk({tag, " clken"},   cfg_clken_o,   m_reg[6]);
        chk({tag, " timeout"}, cfg_timeout_o, m_reg[7]);
        chk({tag, " cwidth"},  cfg_cwidth_o,  m_reg[8]);
        chk({tag, " blksize"}, cfg_blksize_o, m_reg[9]);
        chk({tag, " bytecnt"}, cfg_bytecnt_o, m_reg[10]);
        chk({tag, " arg"},     cfg_arg_o,     m_reg[11]);
        chk({tag, " cmd"},     cfg_cmd_o,     {m_locked, m_reg[12][30:0]});
        chk({tag, " pending"}, {31'b0, cmd_pending_o}, {31'b0, m_locked});
        chk({tag, " irq"},     {31'b0, irq_o}, {31'b0, m_irq()});
    endtask

    // driver: one write (optionally with accept) then update the model
    task automatic bus_wr(input int a, input logic [31:0] d, input bit acc);
        bit was;
        @(negedge clk);
        host_wr_i = 1'b1; host_addr_i = 5'(a); host_wdata_i = d; card_accept_i = acc;
        @(negedge clk);
        host_wr_i = 1'b0; card_accept_i = 1'b0;
        was = m_locked;
        if (a >= 4 && a <= 12) begin
            if (was) m_raw[12] = 1'b1;
            else m_reg[a] = (a == 12) ? {1'b0, d[30:0]} : d;
        end else if (a == 0) m_gen = d[0];
        else if (a == 1) m_mask = d[15:0];
        else if (a == 2) m_raw = m_raw & ~d[15:0];
        m_locked = was ? !acc : (a == 12 && d[31]);
    endtask

    task automatic bus_acc();
        @(negedge clk);
        card_accept_i = 1'b1;
        @(negedge clk);
        card_accept_i = 1'b0;
        if (m_locked) m_locked = 1'b0;
    endtask

    // driver: read, pushing the expected word to the scoreboard
    task automatic bus_rd(input int a, input string tag);
        @(negedge clk);
        host_rd_i = 1'b1; host_addr_i = 5'(a);
        exp_q.push_back(exp_rd(a));
        tag_q.push_back(tag);
        @(negedge clk);
        host_rd_i = 1'b0;
    endtask

    always @(posedge clk) rd_d <= host_rd_i;

    // monitor: read data is valid the cycle after the strobe (R10)
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10: unexpected read data %h expected none", host_rdata_o);
            end else begin
                chk(tag_q.pop_front(), host_rdata_o, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        m_reg[7] = 32'hFFFF_FFFF; m_reg[9] = 32'h200; m_reg[10] = 32'h200;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R10 unmapped reads
        chk_outs("R1");
        for (int a = 0; a < 16; a++) bus_rd(a, (a == 3 || a > 12) ? "R10 unmapped" : "R1 reset");

        // R12 outputs follow writes
        bus_wr(4, 32'h3, 0);  bus_wr(5, 32'h1, 0);  bus_wr(6, 32'hF, 0);
        bus_wr(7, 32'h00FF_0040, 0); bus_wr(8, 32'h2, 0); bus_wr(9, 32'h40, 0);
        bus_wr(10, 32'h100, 0); bus_wr(11, 32'hCAFE_0001, 0);
        chk_outs("R12");

        // R2 command without start bit stores but does not lock
        bus_wr(12, 32'h0000_0011, 0);
        chk_outs("R2 nostart");
        bus_wr(1, 32'h1000, 0); bus_wr(0, 32'h1, 0);

        // R2 start
        bus_wr(12, 32'h8000_2251, 0);
        chk_outs("R2 start");
        bus_rd(12, "R2 readback");

        // R3 / R4 locked writes dropped and flagged, R9 irq
        bus_wr(11, 32'h1234_5678, 0);
        bus_wr(9, 32'h1FF, 0);
        bus_wr(12, 32'h8000_0099, 0);
        chk_outs("R3");
        bus_rd(11, "R3 arg kept");
        bus_rd(2, "R4 raw bit12");
        chk("R9 irq on", {31'b0, irq_o}, 32'h1);

        // R7 mask writable while locked
        bus_wr(1, 32'h0, 0);
        chk_outs("R7 mask off");
        bus_rd(1, "R7 mask read");
        bus_rd(2, "R7 no error");
        bus_wr(1, 32'h1000, 0);

        // R8 write-one-to-clear while locked
        bus_wr(2, 32'h0000_0001, 0);
        bus_rd(2, "R8 zero-bit keeps");
        bus_wr(2, 32'h0000_1000, 0);
        bus_rd(2, "R8 cleared");
        chk_outs("R8");

        // R6 write in accept cycle dropped, R5 release
        bus_wr(11, 32'h0000_DEAD, 1);
        chk_outs("R6");
        bus_rd(2, "R6 error flagged");
        bus_rd(12, "R5 start bit clear");
        bus_wr(11, 32'h0000_BEEF, 0);
        chk_outs("R5 write after accept");

        // R11 accept while unlocked
        bus_acc();
        chk_outs("R11");
        bus_rd(12, "R11 readback");

        // R9 global enable gating
        bus_wr(0, 32'h0, 0);
        chk_outs("R9 gen off");
        bus_wr(0, 32'h1, 0);
        chk_outs("R9 gen on");
        bus_wr(2, 32'hFFFF, 0);

        // R10 unmapped writes ignored
        bus_wr(3, 32'hFFFF_FFFF, 0);
        bus_wr(13, 32'hFFFF_FFFF, 0);
        bus_wr(31, 32'hFFFF_FFFF, 0);
        bus_rd(3, "R10 addr3");
        bus_rd(13, "R10 addr13");
        bus_rd(2, "R10 no error");
        chk_outs("R10");

        repeat (3) @(negedge clk);
        chk("R10 scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule